// File: doc/BRIEF.md
# ECC Control and Status Register with Error Injection

This block is one 32-bit control and status register that governs error-correcting-code protection for two on-chip buffer RAMs. RAM index 0 is the transmit-path buffer and RAM index 1 is the receive-path buffer. Software uses the register for three things. It switches protection on with a global enable. It asks for exactly one corrupted write into a chosen RAM, either a correctable single-bit error or an uncorrectable double-bit error. It observes sticky error flags that the RAMs' checkers raise, and the block folds those flags into one interrupt line.

An injection request is armed only when a trigger bit goes from 0 to 1 through a register write. The request then waits until the next write strobe of the target RAM. On that strobe the matching inject output is asserted in the same cycle, and the request is then spent. Error flags are set by hardware and cleared by writing 1 to them. Only the cold reset clears the register. The warm reset input is accepted and has no effect.

Top module: `ecc_ctrl_reg`

## Requirements
- R1: One cycle after a clock edge with `cold_rst` high, `reg_rdata` reads 0, `irq` is 0, and no injection request is pending.
- R2: Bit 0 of the register is the ECC enable. A register write stores `reg_wdata[0]` there, and the stored value reads back on `reg_rdata[0]`.
- R3: Bits 31 to 9 always read as 0, whatever value was written to them.
- R4: Bits 1 to 4 are trigger bits that read back their last written value. Their meanings are: bit 1 transmit single-bit, bit 2 transmit double-bit, bit 3 receive single-bit, bit 4 receive double-bit.
- R5: A write that takes a trigger bit from 0 to 1 arms one request. On the next cycle in which the matching `ram_wr[i]` is high, the block asserts `inj_sbe[i]` (single-bit triggers) or `inj_dbe[i]` (double-bit triggers) combinationally in that same cycle. The request is then spent, so later writes to that RAM are clean. An inject output is never high while its `ram_wr` bit is low.
- R6: Writing 1 to a trigger bit that already holds 1 arms nothing. Two or more 0-to-1 transitions made while a request is still pending merge into one injection.
- R7: While the enable is 1, `err_sbe[i]` or `err_dbe[i]` sets a status bit one cycle later. The bits are: bit 5 transmit single-bit, bit 6 transmit double-bit, bit 7 receive single-bit, bit 8 receive double-bit. Status bits stay set until they are cleared.
- R8: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R9: When an enabled error event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: While the enable is 0, error event inputs do not change any status bit.
- R11: `irq` is high exactly when the enable bit is 1 and at least one status bit is 1.
- R12: `warm_rst` has no effect on any register bit or on pending injection requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset; clears everything |
| warm_rst | input | 1 | Warm reset; ignored by this register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| irq | output | 1 | ECC interrupt (enable AND any status bit) |
| ram_wr | input | 2 | Write strobe per RAM (0 transmit, 1 receive) |
| inj_sbe | output | 2 | Corrupt this write with a single-bit error, per RAM |
| inj_dbe | output | 2 | Corrupt this write with a double-bit error, per RAM |
| err_sbe | input | 2 | Correctable error reported by a RAM's checker |
| err_dbe | input | 2 | Uncorrectable error reported by a RAM's checker |

## Verification
The bench rewrites a trigger bit that is already set. A design that detected levels instead of edges would then inject a second time. It also produces two rising edges while a request is still pending. A queueing design would then corrupt two RAM writes instead of one. It lands a hardware error event and a write-1 clear on the same status bit in the same cycle, which exposes any design in which the clear wins and the event is lost. It also disables ECC while flags are set and while events keep arriving, to catch an interrupt that is not gated by the enable or a flag that keeps capturing events. Finally it holds warm reset while state is loaded, to catch a register that clears on the wrong reset.

// File: rtl/ecc_reg_pkg.sv
package ecc_reg_pkg;

    localparam int NUM_RAMS = 2;
    localparam int KINDS    = 2;
    localparam int NTRIG    = NUM_RAMS * KINDS;
    localparam int EN_BIT   = 0;
    localparam int TRIG_LSB = EN_BIT + 1;
    localparam int STAT_LSB = TRIG_LSB + NTRIG;
    localparam int USED_W   = STAT_LSB + NTRIG;

    typedef enum int {KIND_SINGLE = 0, KIND_DOUBLE = 1} err_kind_e;

    typedef struct packed {
        logic [NTRIG-1:0] status;
        logic [NTRIG-1:0] trig;
        logic             en;
    } ctrl_view_t;

    function automatic logic [NTRIG-1:0] pack_pairs(
        input logic [NUM_RAMS-1:0] sgl,
        input logic [NUM_RAMS-1:0] dbl
    );
        logic [NTRIG-1:0] v;
        for (int r = 0; r < NUM_RAMS; r++) begin
            v[KINDS*r + KIND_SINGLE] = sgl[r];
            v[KINDS*r + KIND_DOUBLE] = dbl[r];
        end
        return v;
    endfunction

endpackage

// File: rtl/ecc_inject_req.sv
module ecc_inject_req #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] arm,
    input  logic           ram_wr,
    output logic [NUM-1:0] inj
);
    logic [NUM-1:0] pend_q;

    assign inj = pend_q & {NUM{ram_wr}};

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~inj) | arm;
    end
endmodule

// File: rtl/ecc_sticky_status.sv
module ecc_sticky_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    logic [N-1:0] set_v;

    assign set_v = evt & {N{en}};

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= set_v | (status & ~clr);
    end
endmodule

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
    import ecc_reg_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                clk,
    input  logic                cold_rst,
    input  logic                warm_rst,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq,
    input  logic [NUM_RAMS-1:0] ram_wr,
    output logic [NUM_RAMS-1:0] inj_sbe,
    output logic [NUM_RAMS-1:0] inj_dbe,
    input  logic [NUM_RAMS-1:0] err_sbe,
    input  logic [NUM_RAMS-1:0] err_dbe
);
    localparam int PAD_W = REG_W - USED_W;

    ctrl_view_t       wr_view;
    ctrl_view_t       rd_view;
    logic             en_q;
    logic [NTRIG-1:0] trig_q;
    logic [NTRIG-1:0] stat_q;
    logic [NTRIG-1:0] rise;
    logic [NTRIG-1:0] clr;

    assign wr_view = ctrl_view_t'(reg_wdata[USED_W-1:0]);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            en_q   <= 1'b0;
            trig_q <= '0;
        end else if (reg_wr) begin
            en_q   <= wr_view.en;
            trig_q <= wr_view.trig;
        end
    end

    assign rise = {NTRIG{reg_wr}} & wr_view.trig & ~trig_q;
    assign clr  = {NTRIG{reg_wr}} & wr_view.status;

    for (genvar r = 0; r < NUM_RAMS; r++) begin : g_ram
        logic [KINDS-1:0] inj_pair;
        ecc_inject_req #(.NUM(KINDS)) u_inj (
            .clk    (clk),
            .rst    (cold_rst),
            .arm    (rise[KINDS*r +: KINDS]),
            .ram_wr (ram_wr[r]),
            .inj    (inj_pair)
        );
        assign inj_sbe[r] = inj_pair[KIND_SINGLE];
        assign inj_dbe[r] = inj_pair[KIND_DOUBLE];
    end

    ecc_sticky_status #(.N(NTRIG)) u_stat (
        .clk    (clk),
        .rst    (cold_rst),
        .en     (en_q),
        .evt    (pack_pairs(err_sbe, err_dbe)),
        .clr    (clr),
        .status (stat_q)
    );

    assign rd_view.en     = en_q;
    assign rd_view.trig   = trig_q;
    assign rd_view.status = stat_q;

    assign reg_rdata = {{PAD_W{1'b0}}, rd_view};
    assign irq       = en_q & (|stat_q);
endmodule

// File: rtl/ecc_ctrl_reg_chk.sv
module ecc_ctrl_reg_chk
    import ecc_reg_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic                clk,
    input logic                cold_rst,
    input logic                warm_rst,
    input logic                reg_wr,
    input logic [REG_W-1:0]    reg_wdata,
    input logic [REG_W-1:0]    reg_rdata,
    input logic                irq,
    input logic [NUM_RAMS-1:0] ram_wr,
    input logic [NUM_RAMS-1:0] inj_sbe,
    input logic [NUM_RAMS-1:0] inj_dbe,
    input logic [NUM_RAMS-1:0] err_sbe,
    input logic [NUM_RAMS-1:0] err_dbe
);
    logic [NTRIG-1:0] evt;
    logic [NTRIG-1:0] stat;
    assign evt  = pack_pairs(err_sbe, err_dbe);
    assign stat = reg_rdata[USED_W-1:STAT_LSB];

    p_cold_clears_r1: assert property (@(posedge clk)
        cold_rst |=> (reg_rdata == '0 && !irq));

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (cold_rst)
        (reg_wr && |reg_wdata[REG_W-1:USED_W]) |=> reg_rdata[REG_W-1:USED_W] == '0);

    p_inj_with_write_r5: assert property (@(posedge clk) disable iff (cold_rst)
        ((inj_sbe | inj_dbe) & ~ram_wr) == '0);

    p_event_captured_r9: assert property (@(posedge clk) disable iff (cold_rst)
        reg_rdata[EN_BIT] |=> (($past(evt) & ~stat) == '0));

    p_disabled_holds_r10: assert property (@(posedge clk) disable iff (cold_rst)
        (!reg_rdata[EN_BIT] && !reg_wr) |=> stat == $past(stat));

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (cold_rst)
        irq == (reg_rdata[EN_BIT] && |stat));

    p_warm_ignored_r12: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && !reg_wr) |=> reg_rdata[STAT_LSB-1:0] == $past(reg_rdata[STAT_LSB-1:0]));
endmodule

bind ecc_ctrl_reg ecc_ctrl_reg_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_ecc_ctrl_reg.sv
module sim_ecc_ctrl_reg;
    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  ram_wr = '0;
    logic [1:0]  inj_sbe, inj_dbe;
    logic [1:0]  err_sbe = '0;
    logic [1:0]  err_dbe = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ecc_ctrl_reg u0 (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .ram_wr(ram_wr), .inj_sbe(inj_sbe), .inj_dbe(inj_dbe),
        .err_sbe(err_sbe), .err_dbe(err_dbe)
    );

    // {write data, expected readback}, starting from the cleared state, no events
    localparam logic [63:0] VEC [8] = '{
        {32'h0000_0001, 32'h0000_0001},
        {32'hFFFF_FE01, 32'h0000_0001},
        {32'h0000_0003, 32'h0000_0003},
        {32'h0000_001E, 32'h0000_001E},
        {32'h0000_0014, 32'h0000_0014},
        {32'hFFFF_FFE0, 32'h0000_0000},
        {32'h0000_0009, 32'h0000_0009},
        {32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic do_cold;
        @(negedge clk);
        cold_rst = 1'b1;
        @(negedge clk);
        cold_rst = 1'b0;
    endtask

    task automatic pulse_err(input logic [1:0] s, input logic [1:0] d);
        @(negedge clk);
        err_sbe = s;
        err_dbe = d;
        @(negedge clk);
        err_sbe = '0;
        err_dbe = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n_inj;
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 inj", {28'b0, inj_sbe, inj_dbe}, 32'h0);

        // R2 R3 R4 table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][63:32]);
            chk("R2/R3/R4 table", reg_rdata, VEC[i][31:0]);
        end

        // R5 single shot on transmit single
        do_cold();
        wr(32'h2);
        chk("R5 no inj without write", {28'b0, inj_sbe, inj_dbe}, 32'h0);
        @(negedge clk); ram_wr = 2'b01; #1;
        chk("R5 tx sbe fires", {28'b0, inj_sbe, inj_dbe}, 32'b0100);
        @(negedge clk); #1;
        chk("R5 spent after one write", {28'b0, inj_sbe, inj_dbe}, 32'h0);
        @(negedge clk); ram_wr = 2'b00;

        // R6 rewriting a set trigger arms nothing
        wr(32'h2);
        @(negedge clk); ram_wr = 2'b01; #1;
        chk("R6 no re-arm on level", {28'b0, inj_sbe, inj_dbe}, 32'h0);
        @(negedge clk); ram_wr = 2'b00;

        // R6 merge of two rises while pending
        wr(32'h0); wr(32'h2); wr(32'h0); wr(32'h2);
        n_inj = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); ram_wr = 2'b01; #1;
            if (inj_sbe[0]) n_inj++;
        end
        @(negedge clk); ram_wr = 2'b00;
        chk("R6 merged count", n_inj, 1);

        // R5 receive double goes only to receive RAM
        wr(32'h10);
        @(negedge clk); ram_wr = 2'b11; #1;
        chk("R5 rx dbe only", {28'b0, inj_sbe, inj_dbe}, 32'b0010);
        @(negedge clk); ram_wr = 2'b00;

        // R7 status capture and bit order, R11 irq
        do_cold();
        wr(32'h1);
        pulse_err(2'b01, 2'b00);
        chk("R7 tx sbe -> bit5", reg_rdata, 32'h21);
        pulse_err(2'b00, 2'b10);
        chk("R7 rx dbe -> bit8", reg_rdata, 32'h121);
        chk("R11 irq set", {31'b0, irq}, 32'h1);

        // R8 write-1-clear
        wr(32'h21);
        chk("R8 clear bit5", reg_rdata, 32'h101);
        wr(32'h1);
        chk("R8 write 0 keeps", reg_rdata, 32'h101);
        wr(32'h101);
        chk("R8 clear bit8", reg_rdata, 32'h1);
        chk("R11 irq clear", {31'b0, irq}, 32'h0);

        // R9 set beats clear
        pulse_err(2'b00, 2'b01);
        chk("R7 tx dbe -> bit6", reg_rdata, 32'h41);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h41; err_dbe = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; err_dbe = '0;
        chk("R9 set wins", reg_rdata, 32'h41);

        // R10 disabled ignores events; R11 gating
        wr(32'h40);
        chk("R10 disable and clear", reg_rdata, 32'h0);
        pulse_err(2'b11, 2'b11);
        chk("R10 events ignored", reg_rdata, 32'h0);
        wr(32'h1);
        pulse_err(2'b10, 2'b00);
        chk("R7 rx sbe -> bit7", reg_rdata, 32'h81);
        wr(32'h0);
        chk("R11 status kept when off", reg_rdata, 32'h80);
        chk("R11 irq gated by enable", {31'b0, irq}, 32'h0);

        // R12 warm reset ignored, including a pending request
        wr(32'h9);
        @(negedge clk); warm_rst = 1'b1;
        repeat (3) @(negedge clk);
        warm_rst = 1'b0;
        chk("R12 register kept", reg_rdata, 32'h89);
        @(negedge clk); ram_wr = 2'b10; #1;
        chk("R12 pending kept", {28'b0, inj_sbe, inj_dbe}, 32'b1000);
        @(negedge clk); ram_wr = 2'b00;

        // R1 cold reset clears all, pending too
        wr(32'h8B);
        do_cold();
        chk("R1 cold clears", reg_rdata, 32'h0);
        @(negedge clk); ram_wr = 2'b11; #1;
        chk("R1 pending cleared", {28'b0, inj_sbe, inj_dbe}, 32'h0);
        @(negedge clk); ram_wr = 2'b00;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule